// File: doc/BRIEF.md
# SDRAM Start-up Sequencer

This block brings a single-data-rate SDRAM from power-on to a usable state. After reset it holds the clock enable high and sends no-operation commands for a long quiet period. It then closes every bank, runs a configurable number of auto-refresh cycles, and loads the normal mode word followed by the extended mode word. Each of these commands lasts one clock, and no-operation commands fill every cycle in between. The command pins, bank address and address bus are all driven by the block. Once the last required gap has passed, it raises `init_done` and keeps driving no-operation commands, so that normal traffic logic can take over the pins.

Every wait is a whole number of clocks worked out from a clock-period parameter and the timing parameters, rounded up, and never less than two clocks. The mode word (burst length code, burst type, CAS latency, single-location write bursts) and the extended word (output drive strength, self-refresh array span) come from parameters. A simulation parameter can replace the long quiet period with a short clock count.

The controller is a single state machine. Its states are ST_QUIET, ST_PRECHARGE, ST_WAIT_RP, ST_REFRESH, ST_WAIT_RC, ST_MODE, ST_WAIT_MRD, ST_EXT_MODE, ST_WAIT_EXT and ST_DONE. Its transitions are:
- ST_QUIET goes to ST_PRECHARGE when the quiet count runs out.
- ST_PRECHARGE goes to ST_WAIT_RP unconditionally.
- ST_WAIT_RP goes to ST_REFRESH when the wait timer expires.
- ST_REFRESH goes to ST_WAIT_RC unconditionally.
- ST_WAIT_RC goes back to ST_REFRESH on expiry while refreshes remain, and to ST_MODE on expiry once none remain.
- ST_MODE goes to ST_WAIT_MRD unconditionally.
- ST_WAIT_MRD goes to ST_EXT_MODE on expiry.
- ST_EXT_MODE goes to ST_WAIT_EXT unconditionally.
- ST_WAIT_EXT goes to ST_DONE on expiry.
- ST_DONE stays in ST_DONE.
- Reset returns the machine to ST_QUIET from any state.

Top module: `sdram_boot_seq`

## Requirements
- R1: The posedges after reset release are numbered from 0. At every one of the first QUIET_CYC of these posedges the pins carry a no-operation command (cs_n=0, ras_n=1, cas_n=1, we_n=1), and `sd_cke` is 1 on every cycle.
- R2: The precharge-all command is captured at posedge number QUIET_CYC. Its encoding is cs_n=0, ras_n=0, cas_n=1, we_n=0, with address bit 10 set, all other address bits 0 and bank address 0.
- R3: The first auto-refresh (cs_n=0, ras_n=0, cas_n=0, we_n=1, address and bank 0) comes exactly RP_CYC clocks after the precharge-all. RP_CYC is the row-precharge time divided by the clock period, rounded up, with a minimum of 2.
- R4: Exactly max(REFRESHES,2) auto-refreshes are issued, RC_CYC clocks apart. The mode-register set follows the last refresh by RC_CYC clocks. RC_CYC is the refresh cycle time divided by the clock period, rounded up, with a minimum of 2.
- R5: The mode-register set drives all four command pins low and bank address 00. Its address word is: A2:A0 = burst length code, A3 = 1 for interleaved bursts, A6:A4 = CAS latency value (2 or 3), A9 = 1 for single-location write bursts. All other bits are 0.
- R6: The extended mode-register set comes MRD_CYC clocks (minimum 2) after the mode-register set. It uses the same pin encoding with bank address 10. Its address word is: A6:A5 = drive strength (00 full, 01 half), A2:A0 = self-refresh span (000 full, 001 half, 010 quarter). All other bits are 0.
- R7: `init_done` first reads 1 at the cycle MRD_CYC clocks after the extended set. It then stays 1, and the pins stay at no-operation.
- R8: Every cycle that carries none of the commands above shows a no-operation command with address and bank address all zero.
- R9: While reset is asserted the pins show no-operation and `init_done` is 0. A reset in mid-sequence or after completion restarts the whole sequence from the quiet period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs change after its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sd_cke | output | 1 | Clock enable to the memory, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address; selects normal or extended mode word |
| sd_addr | output | ADDR_W | Address bus carrying the precharge-all flag and mode words |
| init_done | output | 1 | High once the whole start-up sequence has completed |

## Verification
The state machine drives the pins directly, so a wrong state shows up at the ports on the very next cycle. It appears as a command at the wrong edge, a missing or extra refresh, or a wrong address or bank word. A miscounted wait timer moves every later command by the same offset, and that shift is visible at the first command after the bad wait. The bench compares each sampled cycle against a cycle-exact schedule of commands and words. A skipped, repeated or stuck state therefore fails at the first cycle where the schedule differs, and the reset-restart cases show whether the refresh counter and timer return to their starting values.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

    typedef enum logic [3:0] {
        ST_QUIET,
        ST_PRECHARGE,
        ST_WAIT_RP,
        ST_REFRESH,
        ST_WAIT_RC,
        ST_MODE,
        ST_WAIT_MRD,
        ST_EXT_MODE,
        ST_WAIT_EXT,
        ST_DONE
    } boot_state_t;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_PRE_ALL,
        CMD_REFRESH,
        CMD_MODE,
        CMD_EXT_MODE
    } boot_cmd_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int at_least(input int value, input int floor_v);
        return (value < floor_v) ? floor_v : value;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic cmd_pins_t pins_of(input boot_cmd_t c);
        cmd_pins_t p;
        unique case (c)
            CMD_PRE_ALL:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            CMD_REFRESH:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            CMD_MODE,
            CMD_EXT_MODE: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            default:      p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/boot_wait_timer.sv
module boot_wait_timer #(
    parameter int CNT_W     = 16,
    parameter int RESET_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= CNT_W'(RESET_VAL);
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign expired = (count_q == '0);

    // R3/R4: the count never rises on its own; it only reloads on request
    a_r3_timer_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count_q != '0) |=> (count_q == $past(count_q) - 1'b1))
        else $error("a_r3_timer_monotone");

endmodule

// File: rtl/boot_mode_words.sv
module boot_mode_words #(
    parameter int ADDR_W       = 13,
    parameter int BA_W         = 2,
    parameter int BURST_CODE   = 3,
    parameter int INTERLEAVE   = 0,
    parameter int CAS_LATENCY  = 3,
    parameter int SINGLE_WRITE = 0,
    parameter int HALF_DRIVE   = 0,
    parameter int ARRAY_SPAN   = 0
) (
    output logic [ADDR_W-1:0] pre_all_addr,
    output logic [ADDR_W-1:0] mode_addr,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [BA_W-1:0]   mode_ba,
    output logic [BA_W-1:0]   ext_ba
);

    localparam int BL_FIELD   = BURST_CODE % 8;
    localparam int BT_FIELD   = (INTERLEAVE != 0) ? 8 : 0;
    localparam int CL_FIELD   = (CAS_LATENCY % 8) * 16;
    localparam int WB_FIELD   = (SINGLE_WRITE != 0) ? 512 : 0;
    localparam int DS_FIELD   = (HALF_DRIVE != 0) ? 32 : 0;
    localparam int SPAN_FIELD = ARRAY_SPAN % 8;
    localparam int AP_FIELD   = 1024;

    localparam int MODE_INT = BL_FIELD + BT_FIELD + CL_FIELD + WB_FIELD;
    localparam int EXT_INT  = SPAN_FIELD + DS_FIELD;

    assign pre_all_addr = ADDR_W'(AP_FIELD);
    assign mode_addr    = ADDR_W'(MODE_INT);
    assign ext_addr     = ADDR_W'(EXT_INT);
    assign mode_ba      = '0;
    assign ext_ba       = BA_W'(2);

endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
    import sdram_boot_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int RP_CYC    = 5,
    parameter int RC_CYC    = 16,
    parameter int MRD_CYC   = 2,
    parameter int REFRESHES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             expired,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output boot_cmd_t        cmd,
    output logic             done
);

    localparam int RF_W = $clog2(REFRESHES + 1);
    localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(RP_CYC - 2);
    localparam logic [CNT_W-1:0] RC_LOAD  = CNT_W'(RC_CYC - 2);
    localparam logic [CNT_W-1:0] MRD_LOAD = CNT_W'(MRD_CYC - 2);

    boot_state_t      state_q, state_d;
    logic [RF_W-1:0]  refs_left_q;

    // state register and refresh counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_QUIET;
            refs_left_q <= RF_W'(REFRESHES);
        end else begin
            state_q <= state_d;
            if (state_q == ST_REFRESH) begin
                refs_left_q <= refs_left_q - 1'b1;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:     if (expired) state_d = ST_PRECHARGE;
            ST_PRECHARGE: state_d = ST_WAIT_RP;
            ST_WAIT_RP:   if (expired) state_d = ST_REFRESH;
            ST_REFRESH:   state_d = ST_WAIT_RC;
            ST_WAIT_RC: begin
                if (expired) begin
                    state_d = (refs_left_q != '0) ? ST_REFRESH : ST_MODE;
                end
            end
            ST_MODE:      state_d = ST_WAIT_MRD;
            ST_WAIT_MRD:  if (expired) state_d = ST_EXT_MODE;
            ST_EXT_MODE:  state_d = ST_WAIT_EXT;
            ST_WAIT_EXT:  if (expired) state_d = ST_DONE;
            ST_DONE:      state_d = ST_DONE;
            default:      state_d = ST_QUIET;
        endcase
    end

    // outputs
    always_comb begin
        cmd        = CMD_NOP;
        timer_load = 1'b0;
        timer_val  = '0;
        done       = 1'b0;
        unique case (state_q)
            ST_PRECHARGE: begin
                cmd        = CMD_PRE_ALL;
                timer_load = 1'b1;
                timer_val  = RP_LOAD;
            end
            ST_REFRESH: begin
                cmd        = CMD_REFRESH;
                timer_load = 1'b1;
                timer_val  = RC_LOAD;
            end
            ST_MODE: begin
                cmd        = CMD_MODE;
                timer_load = 1'b1;
                timer_val  = MRD_LOAD;
            end
            ST_EXT_MODE: begin
                cmd        = CMD_EXT_MODE;
                timer_load = 1'b1;
                timer_val  = MRD_LOAD;
            end
            ST_DONE:     done = 1'b1;
            default:     cmd  = CMD_NOP;
        endcase
    end

    // R4: the mode-register set only follows once every refresh is used up
    a_r4_all_refreshes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MODE) |-> (refs_left_q == '0))
        else $error("a_r4_all_refreshes");

    // R9: the done state is left only through reset
    a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (state_q == ST_DONE))
        else $error("a_r9_done_holds");

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
    import sdram_boot_pkg::*;
#(
    parameter int CLK_PERIOD_PS    = 4000,
    parameter int QUIET_US         = 200,
    parameter int SIM_QUIET_CYCLES = 0,
    parameter int T_RP_PS          = 18000,
    parameter int T_RC_PS          = 63000,
    parameter int MRD_CLK          = 2,
    parameter int REFRESHES        = 2,
    parameter int ADDR_W           = 13,
    parameter int BA_W             = 2,
    parameter int BURST_CODE       = 3,
    parameter int INTERLEAVE       = 0,
    parameter int CAS_LATENCY      = 3,
    parameter int SINGLE_WRITE     = 0,
    parameter int HALF_DRIVE       = 0,
    parameter int ARRAY_SPAN       = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_done
);

    localparam int QUIET_REAL = ceil_div(QUIET_US * 1000, CLK_PERIOD_PS) * 1000;
    localparam int QUIET_CYC  = at_least((SIM_QUIET_CYCLES != 0) ? SIM_QUIET_CYCLES : QUIET_REAL, 1);
    localparam int RP_CYC     = at_least(ceil_div(T_RP_PS, CLK_PERIOD_PS), 2);
    localparam int RC_CYC     = at_least(ceil_div(T_RC_PS, CLK_PERIOD_PS), 2);
    localparam int MRD_CYC    = at_least(MRD_CLK, 2);
    localparam int REF_N      = at_least(REFRESHES, 2);
    localparam int GAP_MAX    = max_of(max_of(RP_CYC, RC_CYC), MRD_CYC);
    localparam int CNT_W      = $clog2(max_of(QUIET_CYC, GAP_MAX) + 1);
    localparam int SW         = $clog2(GAP_MAX + 2);

    logic             expired;
    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    boot_cmd_t        cmd;
    logic             done;
    cmd_pins_t        pins;

    logic [ADDR_W-1:0] pre_all_addr, mode_addr, ext_addr;
    logic [BA_W-1:0]   mode_ba, ext_ba;

    boot_seq_fsm #(
        .CNT_W     (CNT_W),
        .RP_CYC    (RP_CYC),
        .RC_CYC    (RC_CYC),
        .MRD_CYC   (MRD_CYC),
        .REFRESHES (REF_N)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .expired    (expired),
        .timer_load (timer_load),
        .timer_val  (timer_val),
        .cmd        (cmd),
        .done       (done)
    );

    boot_wait_timer #(
        .CNT_W     (CNT_W),
        .RESET_VAL (QUIET_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (expired)
    );

    boot_mode_words #(
        .ADDR_W       (ADDR_W),
        .BA_W         (BA_W),
        .BURST_CODE   (BURST_CODE),
        .INTERLEAVE   (INTERLEAVE),
        .CAS_LATENCY  (CAS_LATENCY),
        .SINGLE_WRITE (SINGLE_WRITE),
        .HALF_DRIVE   (HALF_DRIVE),
        .ARRAY_SPAN   (ARRAY_SPAN)
    ) u_words (
        .pre_all_addr (pre_all_addr),
        .mode_addr    (mode_addr),
        .ext_addr     (ext_addr),
        .mode_ba      (mode_ba),
        .ext_ba       (ext_ba)
    );

    // pin decode
    always_comb begin
        pins    = pins_of(cmd);
        sd_addr = '0;
        sd_ba   = '0;
        unique case (cmd)
            CMD_PRE_ALL:  sd_addr = pre_all_addr;
            CMD_MODE: begin
                sd_addr = mode_addr;
                sd_ba   = mode_ba;
            end
            CMD_EXT_MODE: begin
                sd_addr = ext_addr;
                sd_ba   = ext_ba;
            end
            default: begin
                sd_addr = '0;
                sd_ba   = '0;
            end
        endcase
    end

    assign sd_cke    = 1'b1;
    assign sd_cs_n   = pins.cs_n;
    assign sd_ras_n  = pins.ras_n;
    assign sd_cas_n  = pins.cas_n;
    assign sd_we_n   = pins.we_n;
    assign init_done = done;

    // checker state: last command issued and the clocks since it
    boot_cmd_t     chk_last_cmd;
    logic [SW-1:0] chk_since;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_last_cmd <= CMD_NOP;
            chk_since    <= '0;
        end else if (cmd != CMD_NOP) begin
            chk_last_cmd <= cmd;
            chk_since    <= SW'(1);
        end else if (chk_since != '1) begin
            chk_since <= chk_since + 1'b1;
        end
    end

    a_r2_precharge_first: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE_ALL) |-> (chk_last_cmd == CMD_NOP))
        else $error("a_r2_precharge_first");

    a_r3_first_refresh_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REFRESH && chk_last_cmd == CMD_PRE_ALL) |-> (chk_since == SW'(RP_CYC)))
        else $error("a_r3_first_refresh_gap");

    a_r4_refresh_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REFRESH && chk_last_cmd == CMD_REFRESH) |-> (chk_since == SW'(RC_CYC)))
        else $error("a_r4_refresh_gap");

    a_r5_mode_after_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MODE) |-> (chk_last_cmd == CMD_REFRESH && chk_since == SW'(RC_CYC)))
        else $error("a_r5_mode_after_refresh");

    a_r6_ext_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_EXT_MODE) |-> (chk_last_cmd == CMD_MODE && chk_since == SW'(MRD_CYC)))
        else $error("a_r6_ext_gap");

    a_r7_done_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (chk_last_cmd == CMD_EXT_MODE && chk_since == SW'(MRD_CYC)))
        else $error("a_r7_done_gap");

    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done)
        else $error("a_r7_done_sticky");

    a_r8_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111 && sd_addr == '0))
        else $error("a_r8_idle_pins");

endmodule

// File: tb/sim_sdram_boot_seq.sv
module sim_sdram_boot_seq;

    // Expected schedule for: quiet 20, tRP 18 ns and tRC 63 ns at 4 ns -> 5 and 16 clocks,
    // three refreshes, mode-to-extended and extended-to-done gaps of 2 clocks.
    localparam int NEV     = 6;
    localparam int DONE_AT = 77;
    localparam int QUIET   = 20;
    localparam int EV_AT   [NEV] = '{20, 25, 41, 57, 73, 75};
    localparam logic [3:0]  EV_PINS [NEV] = '{4'b0010, 4'b0001, 4'b0001, 4'b0001, 4'b0000, 4'b0000};
    localparam logic [1:0]  EV_BA   [NEV] = '{2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b10};
    localparam logic [12:0] EV_ADDR [NEV] = '{13'h400, 13'h000, 13'h000, 13'h000, 13'h22A, 13'h022};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    always #2 clk = ~clk;

    sdram_boot_seq #(
        .CLK_PERIOD_PS    (4000),
        .SIM_QUIET_CYCLES (QUIET),
        .REFRESHES        (3),
        .BURST_CODE       (2),
        .INTERLEAVE       (1),
        .CAS_LATENCY      (2),
        .SINGLE_WRITE     (1),
        .HALF_DRIVE       (1),
        .ARRAY_SPAN       (2)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .sd_cke    (sd_cke),
        .sd_cs_n   (sd_cs_n),
        .sd_ras_n  (sd_ras_n),
        .sd_cas_n  (sd_cas_n),
        .sd_we_n   (sd_we_n),
        .sd_ba     (sd_ba),
        .sd_addr   (sd_addr),
        .init_done (init_done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected under 20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input int n, input logic [31:0] act, input logic [31:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fails = n_fails + 1;
            $display("FAIL %s at sample %0d: actual %h expected %h", tag, n, act, exp);
        end
    endtask

    function automatic string tag_of(input int k);
        case (k)
            0:       return "R2";
            1:       return "R3";
            2, 3:    return "R4";
            4:       return "R5";
            default: return "R6";
        endcase
    endfunction

    // check one sample against the schedule
    task automatic check_sample(input int n);
        logic [3:0]  ep;
        logic [1:0]  eb;
        logic [12:0] ea;
        string       tag;
        ep  = 4'b0111;
        eb  = 2'b00;
        ea  = 13'h000;
        tag = (n < QUIET) ? "R1" : "R8";
        for (int k = 0; k < NEV; k++) begin
            if (EV_AT[k] == n) begin
                ep  = EV_PINS[k];
                eb  = EV_BA[k];
                ea  = EV_ADDR[k];
                tag = tag_of(k);
            end
        end
        chk(tag, n, {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, {28'd0, ep});
        chk(tag, n, {30'd0, sd_ba}, {30'd0, eb});
        chk(tag, n, {19'd0, sd_addr}, {19'd0, ea});
        chk("R1", n, {31'd0, sd_cke}, 32'd1);
        chk("R7", n, {31'd0, init_done}, (n >= DONE_AT) ? 32'd1 : 32'd0);
    endtask

    // release reset and walk the vector table up to sample 'upto'
    task automatic walk(input int upto);
        @(negedge clk);
        rst_n = 1'b1;
        check_sample(0);
        for (int n = 1; n <= upto; n++) begin
            @(negedge clk);
            check_sample(n);
        end
    endtask

    task automatic hold_reset(input int cycles);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk("R9", i, {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 32'h7);
            chk("R9", i, {31'd0, init_done}, 32'd0);
            chk("R9", i, {19'd0, sd_addr}, 32'd0);
        end
    endtask

    initial begin
        // reset state
        repeat (3) @(negedge clk);
        chk("R9", 0, {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 32'h7);
        chk("R9", 0, {31'd0, init_done}, 32'd0);
        chk("R1", 0, {31'd0, sd_cke}, 32'd1);

        // full sequence plus a tail to confirm init_done holds (R7, R8)
        walk(DONE_AT + 12);

        // reset after completion: must drop done and restart (R9)
        hold_reset(3);
        walk(50);

        // reset mid-sequence, between refreshes: full restart (R9)
        hold_reset(4);
        walk(DONE_AT + 5);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule